// File: doc/BRIEF.md
# Row Activation Throttle

This block sits between a memory controller's command scheduler and the activate issue port of a DRAM channel. It limits how often any single row can be opened, which guards against disturbance errors in neighbouring rows. Each activate request carries a bank and a row. The block compares the pair against a small fully associative table of recently opened rows. It then raises or lowers `act_ready_o` in the same cycle. An activate is issued only in a cycle where both `act_valid_i` and `act_ready_o` are high.

Two limits apply to each tracked row. First, two grants of the same row must be at least `MIN_GAP` clock cycles apart, which is a fixed time interval expressed in cycles. Second, a row may be granted at most `MAX_ACT` times between two pulses of `window_tick_i`, which marks the start of each refresh window. A request that breaks either limit is held. The block evaluates it again every cycle. If the spacing limit is the cause, the request is released as soon as the spacing is met. If the count limit is the cause, the request waits for the next window pulse. The output `viol_count_o` counts every cycle in which a request was held.

Top module: `row_act_throttle`

## Requirements
- R1: After reset the table is empty and `viol_count_o` is 0. Any request presented in the first cycle after reset sees `act_ready_o` high.
- R2: After a grant of a row, requests for that same row see `act_ready_o` low for the next `MIN_GAP`-1 cycles. The request is granted at the earliest in cycle `MIN_GAP` after the grant cycle.
- R3: Once a row has been granted `MAX_ACT` times within one window, further requests for it see `act_ready_o` low, even after the spacing has been met.
- R4: A `window_tick_i` pulse clears every row's count at the clock edge that ends the pulse cycle. A capped request presented during the pulse cycle is still held in that cycle and is granted in the following cycle.
- R5: A row is identified by the concatenation {bank, row}. A grant to one pair does not delay requests for any other pair, including the same row number in a different bank.
- R6: A pair that is not in the table sees `act_ready_o` high in the same cycle. On its grant, the pair takes the lowest-numbered empty entry. If no entry is empty, it replaces the entry whose last grant is oldest. Held requests do not change this recency order.
- R7: `viol_count_o` increases by 1 at each edge that ends a cycle with `act_valid_i` high and `act_ready_o` low, and saturates at all ones. In every other cycle it holds its value, even when `act_ready_o` is low while `act_valid_i` is low.
- R8: A cycle with `act_valid_i` low leaves the table unchanged: it allocates nothing and counts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_valid_i | input | 1 | An activate is requested |
| act_bank_i | input | BANK_W | Bank of the requested activate |
| act_row_i | input | ROW_W | Row of the requested activate |
| window_tick_i | input | 1 | One-cycle pulse at the start of each refresh window |
| act_ready_o | output | 1 | The activate may issue in this cycle |
| viol_count_o | output | VIOL_W | Saturating count of held request cycles |

## Verification
Several properties are checked on every cycle:
- No entry is granted while its spacing or count limit is unmet.
- No count ever exceeds `MAX_ACT`.
- A window pulse always leaves counts at zero.
- At most one entry matches a request.
- Exactly one entry holds the oldest recency rank.
- The violation counter steps only on held valid cycles.
- Idle cycles never alter the table.

Other behaviours can only be shown by the bench's request sequences:
- The exact cycle in which a spaced request is released.
- Which entry the replacement policy chooses.
- That a request held during the window pulse cycle is released one cycle later.
- That other banks and rows proceed freely.

// File: rtl/row_act_pkg.sv
package row_act_pkg;
  typedef enum logic [1:0] {
    LK_MISS    = 2'd0,
    LK_OPEN    = 2'd1,
    LK_SPACING = 2'd2,
    LK_CAPPED  = 2'd3
  } lookup_e;
endpackage

// File: rtl/rat_entry.sv
module rat_entry #(
  parameter int TAG_W   = 19,
  parameter int MIN_GAP = 100,
  parameter int MAX_ACT = 131072
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             alloc_i,
  input  logic             touch_i,
  input  logic             clear_i,
  output logic             valid_o,
  output logic             hit_o,
  output logic             gap_ok_o,
  output logic             cap_ok_o
);
  localparam int AGE_W = $clog2(MIN_GAP + 1);
  localparam int CNT_W = $clog2(MAX_ACT + 1);

  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic [AGE_W-1:0] age_q;  // cycles since last grant, saturating at MIN_GAP
  logic [CNT_W-1:0] cnt_q;

  assign valid_o  = valid_q;
  assign hit_o    = valid_q && (tag_q == tag_i);
  assign gap_ok_o = age_q >= AGE_W'(MIN_GAP);
  assign cap_ok_o = cnt_q < CNT_W'(MAX_ACT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      age_q   <= AGE_W'(MIN_GAP);
      cnt_q   <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      tag_q   <= tag_i;
      age_q   <= AGE_W'(1);
      cnt_q   <= CNT_W'(1);
    end else if (touch_i) begin
      age_q <= AGE_W'(1);
      cnt_q <= clear_i ? CNT_W'(1) : cnt_q + 1'b1;
    end else begin
      if (age_q < AGE_W'(MIN_GAP)) age_q <= age_q + 1'b1;
      if (clear_i) cnt_q <= '0;
    end
  end

  assert_touch_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |-> gap_ok_o);
  assert_touch_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |-> cap_ok_o);
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_ACT));
  assert_window_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !alloc_i && !touch_i) |=> (cnt_q == '0));
endmodule

// File: rtl/rat_lru.sv
module rat_lru #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [N-1:0]     valid_i,
  output logic [IDX_W-1:0] victim_o
);
  // rank 0 = most recent grant, N-1 = oldest
  logic [IDX_W-1:0] rank_q [N];
  logic [N-1:0]     is_old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx_i)               rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[touch_idx_i])   rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign is_old[g] = (rank_q[g] == IDX_W'(N - 1));
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!valid_i[i] && !found) begin
        victim_o = IDX_W'(i);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) if (is_old[i]) victim_o = IDX_W'(i);
    end
  end

  assert_single_oldest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(is_old) == 1);
endmodule

// File: rtl/row_act_throttle.sv
module row_act_throttle
  import row_act_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 16,
  parameter int MIN_GAP = 100,
  parameter int MAX_ACT = 131072,
  parameter int VIOL_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_valid_i,
  input  logic [BANK_W-1:0] act_bank_i,
  input  logic [ROW_W-1:0]  act_row_i,
  input  logic              window_tick_i,
  output logic              act_ready_o,
  output logic [VIOL_W-1:0] viol_count_o
);
  localparam int TAG_W = BANK_W + ROW_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [TAG_W-1:0]   tag;
  logic [ENTRIES-1:0] valid_vec, hit_vec, gap_vec, cap_vec, alloc_vec, touch_vec;
  logic [IDX_W-1:0]   hit_idx, victim;
  logic               hit, grant;
  lookup_e            lookup;
  logic [VIOL_W-1:0]  viol_q;

  assign tag = {act_bank_i, act_row_i};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    rat_entry #(
      .TAG_W  (TAG_W),
      .MIN_GAP(MIN_GAP),
      .MAX_ACT(MAX_ACT)
    ) u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tag_i   (tag),
      .alloc_i (alloc_vec[g]),
      .touch_i (touch_vec[g]),
      .clear_i (window_tick_i),
      .valid_o (valid_vec[g]),
      .hit_o   (hit_vec[g]),
      .gap_ok_o(gap_vec[g]),
      .cap_ok_o(cap_vec[g])
    );
    assign alloc_vec[g] = grant && !hit && (victim == IDX_W'(g));
    assign touch_vec[g] = grant && hit_vec[g];
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) if (hit_vec[i]) hit_idx = IDX_W'(i);
  end
  assign hit = |hit_vec;

  always_comb begin
    if (!hit)                  lookup = LK_MISS;
    else if (!gap_vec[hit_idx]) lookup = LK_SPACING;
    else if (!cap_vec[hit_idx]) lookup = LK_CAPPED;
    else                       lookup = LK_OPEN;
  end

  assign act_ready_o = (lookup == LK_MISS) || (lookup == LK_OPEN);
  assign grant       = act_valid_i && act_ready_o;

  rat_lru #(.N(ENTRIES)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (grant),
    .touch_idx_i(hit ? hit_idx : victim),
    .valid_i    (valid_vec),
    .victim_o   (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          viol_q <= '0;
    else if (act_valid_i && !act_ready_o && !(&viol_q))  viol_q <= viol_q + 1'b1;
  end
  assign viol_count_o = viol_q;

  assert_single_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  assert_viol_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_valid_i && !act_ready_o && !(&viol_count_o)) |=> viol_count_o == $past(viol_count_o) + 1'b1);
  assert_viol_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_valid_i && !act_ready_o) |=> $stable(viol_count_o));
  assert_idle_keeps_table_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_valid_i |=> $stable(valid_vec));
endmodule

// File: tb/sim_row_act_throttle.sv
module sim_row_act_throttle;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 8;
  localparam int VIOL_W = 8;

  typedef struct {
    logic  rdy;
    int    viol;
    string req;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0;
  logic [BANK_W-1:0] bank = '0;
  logic [ROW_W-1:0]  row = '0;
  logic              tick = 1'b0;
  logic              ready;
  logic [VIOL_W-1:0] viol;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0, exp_viol = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  row_act_throttle #(
    .ENTRIES(4), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .MIN_GAP(6), .MAX_ACT(4), .VIOL_W(VIOL_W)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .act_valid_i(valid), .act_bank_i(bank),
    .act_row_i(row), .window_tick_i(tick), .act_ready_o(ready), .viol_count_o(viol)
  );

  task automatic step(input logic v, input int b, input int r, input logic t,
                      input logic exp_rdy, input string req);
    exp_t e;
    @(negedge clk);
    valid = v; bank = BANK_W'(b); row = ROW_W'(r); tick = t;
    e.rdy = exp_rdy; e.viol = exp_viol; e.req = req;
    q.push_back(e);
    if (v && !exp_rdy) exp_viol++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 1'b1, "R8 idle");
  endtask

  // monitor: samples 1 ns before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (ready !== e.rdy || int'(viol) != e.viol) begin
          n_fail++;
          $display("FAIL %s: ready=%0b viol=%0d expected ready=%0b viol=%0d",
                   e.req, ready, viol, e.rdy, e.viol);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 0, 0, 1'b0, 1'b1, "R1 reset state");
    // row A = (0,1)
    step(1'b1, 0, 1, 1'b0, 1'b1, "R6 first grant");
    for (int k = 1; k < 6; k++) step(1'b1, 0, 1, 1'b0, 1'b0, "R2 spacing hold");
    step(1'b1, 0, 1, 1'b0, 1'b1, "R2 spacing release");
    idle(5);
    step(1'b1, 0, 1, 1'b0, 1'b1, "R3 third grant");
    idle(5);
    step(1'b1, 0, 1, 1'b0, 1'b1, "R3 fourth grant");
    idle(5);
    for (int k = 0; k < 3; k++) step(1'b1, 0, 1, 1'b0, 1'b0, "R3 cap hold");
    step(1'b1, 0, 1, 1'b1, 1'b0, "R4 tick cycle held");
    step(1'b1, 0, 1, 1'b0, 1'b1, "R4 after tick");
    step(1'b1, 0, 2, 1'b0, 1'b1, "R5 other row");
    step(1'b1, 1, 1, 1'b0, 1'b1, "R5 other bank");
    step(1'b1, 2, 3, 1'b0, 1'b1, "R6 fill");
    step(1'b1, 3, 4, 1'b0, 1'b1, "R6 evicting grant");
    step(1'b1, 0, 2, 1'b0, 1'b0, "R6 recent row kept");
    step(1'b1, 0, 1, 1'b0, 1'b1, "R6 oldest evicted");
    step(1'b1, 1, 1, 1'b0, 1'b0, "R2 other entry hold");
    step(1'b1, 1, 1, 1'b0, 1'b1, "R2 other entry release");
    step(1'b0, 1, 1, 1'b0, 1'b0, "R7 idle hold not counted");
    step(1'b0, 3, 7, 1'b0, 1'b1, "R8 idle new row");
    step(1'b1, 3, 7, 1'b0, 1'b1, "R8 no allocation on idle");
    step(1'b0, 0, 0, 1'b0, 1'b1, "R7 final count");
    @(negedge clk);
    valid = 1'b0;
    repeat (2) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule